// File: doc/BRIEF.md
# Register Rename Unit with Speculative and Committed Map Tables

This block renames architectural integer register names to physical register tags for an out-of-order core. It keeps two map tables. The front map holds the speculative mapping that each new instruction sees. The commit map holds the mapping that belongs to retired instructions only. Physical registers come from a free pool. Reorder-buffer slots are handed out in program order.

Each cycle, at most one instruction is presented on the rename port. It carries two source register numbers and an optional destination. In the same cycle the block returns the physical tags of the sources, a newly allocated destination tag and the reorder-buffer slot. When a retire pulse arrives, the oldest slot commits. No register data moves: the commit map entry for the destination is overwritten, and the physical register it named before goes back to the pool. A flush throws away all unretired work. It copies the commit map into the front map, rebuilds the free pool from the commit map, and empties the reorder buffer.

Top module: `rename_map_unit`

## Requirements
- R1: After reset, both map tables map architectural register i to physical register i, physical registers 0 to NUM_AREGS-1 are busy and all others are free, the reorder buffer is empty, `ren_rob_idx` is 0, and `ren_ready` is 1.
- R2: `ren_tag_a` and `ren_tag_b` show, combinationally, the front map entries for `ren_src_a` and `ren_src_b`. These entries include the destination written by every earlier accepted rename, including one accepted in the previous cycle.
- R3: An accepted rename with `ren_has_dst`=1 takes the lowest-numbered free physical register, shows it on `ren_tag_dst`, marks it busy and, from the next cycle, maps `ren_dst` to it in the front map. A rename with `ren_has_dst`=0 takes no register.
- R4: Accepted renames receive reorder-buffer slots 0, 1, 2 and so on, in order, wrapping from ROB_DEPTH-1 back to 0. ROB_DEPTH is a power of two.
- R5: When the reorder buffer holds ROB_DEPTH entries, `ren_ready` is 0 and nothing is accepted.
- R6: When no physical register is free, `ren_ready` is 0 for a rename with a destination and stays 1 for a rename without one.
- R7: `ret_valid` retires the oldest entry. If that entry has a destination, the commit map entry for it takes the entry's tag, and the register it named before becomes free. That register can be allocated from the next cycle. A retire pulse while the reorder buffer is empty is ignored.
- R8: In a cycle with `flush` high, `ren_ready` is 0 and `ret_valid` is ignored. From the next cycle, the front map equals the commit map, exactly the registers absent from the commit map are free, the reorder buffer is empty, and the next slot handed out is the one after the last retired entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | 3 | First source architectural register |
| ren_src_b | input | 3 | Second source architectural register |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_dst | input | 3 | Destination architectural register |
| ren_ready | output | 1 | Request can be accepted this cycle |
| ren_tag_a | output | 7 | Physical tag of first source |
| ren_tag_b | output | 7 | Physical tag of second source |
| ren_tag_dst | output | 7 | Allocated destination tag |
| ren_rob_idx | output | 7 | Reorder-buffer slot for this request |
| ret_valid | input | 1 | Retire the oldest entry |
| flush | input | 1 | Discard all unretired entries |

## Verification
All rename outputs are combinational, so the tags, slot and ready for a request are due in the same cycle the request is applied. The bench drives each request just after a rising edge and compares it at the following falling edge against a reference model. Table updates, pool changes from allocation and retirement, and flush recovery appear only after the next rising edge. The model therefore applies each update after the comparison for the current request. Each later request observes the effect one cycle after its cause, which covers the reuse of a freed register and the sources read after a flush.

// File: rtl/rename_map_unit.sv
`timescale 1ns/1ps
module rename_map_unit #(
  parameter int NUM_AREGS = 8,
  parameter int NUM_PREGS = 128,
  parameter int ROB_DEPTH = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren_valid,
  input  logic [$clog2(NUM_AREGS)-1:0] ren_src_a,
  input  logic [$clog2(NUM_AREGS)-1:0] ren_src_b,
  input  logic                         ren_has_dst,
  input  logic [$clog2(NUM_AREGS)-1:0] ren_dst,
  output logic                         ren_ready,
  output logic [$clog2(NUM_PREGS)-1:0] ren_tag_a,
  output logic [$clog2(NUM_PREGS)-1:0] ren_tag_b,
  output logic [$clog2(NUM_PREGS)-1:0] ren_tag_dst,
  output logic [$clog2(ROB_DEPTH)-1:0] ren_rob_idx,
  input  logic                         ret_valid,
  input  logic                         flush
);
  localparam int AW = $clog2(NUM_AREGS);
  localparam int PW = $clog2(NUM_PREGS);
  localparam int RW = $clog2(ROB_DEPTH);
  localparam int CW = $clog2(ROB_DEPTH + 1);

  logic [PW-1:0] front_map  [NUM_AREGS];
  logic [PW-1:0] commit_map [NUM_AREGS];
  logic [NUM_PREGS-1:0] free_q;
  logic [NUM_PREGS-1:0] commit_used;
  logic [RW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  logic          ent_dst  [ROB_DEPTH];
  logic [AW-1:0] ent_arch [ROB_DEPTH];
  logic [PW-1:0] ent_tag  [ROB_DEPTH];

  logic [PW-1:0] pick;
  logic any_free, rob_full, fire, alloc, retire;
  logic          ret_dst;
  logic [AW-1:0] ret_arch;
  logic [PW-1:0] ret_tag;

  always_comb begin
    pick = '0;
    for (int i = NUM_PREGS - 1; i >= 0; i--)
      if (free_q[i]) pick = PW'(i);
  end

  always_comb begin
    commit_used = '0;
    for (int a = 0; a < NUM_AREGS; a++)
      commit_used[commit_map[a]] = 1'b1;
  end

  assign any_free    = |free_q;
  assign rob_full    = (cnt_q == CW'(ROB_DEPTH));
  assign ren_ready   = !flush && !rob_full && (!ren_has_dst || any_free);
  assign fire        = ren_valid && ren_ready;
  assign alloc       = fire && ren_has_dst;
  assign retire      = ret_valid && !flush && (cnt_q != '0);
  assign ren_tag_a   = front_map[ren_src_a];
  assign ren_tag_b   = front_map[ren_src_b];
  assign ren_tag_dst = pick;
  assign ren_rob_idx = tail_q;
  assign ret_dst     = ent_dst[head_q];
  assign ret_arch    = ent_arch[head_q];
  assign ret_tag     = ent_tag[head_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_AREGS; a++) begin
        front_map[a]  <= PW'(a);
        commit_map[a] <= PW'(a);
      end
      for (int p = 0; p < NUM_PREGS; p++)
        free_q[p] <= (p >= NUM_AREGS);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      for (int a = 0; a < NUM_AREGS; a++)
        front_map[a] <= commit_map[a];
      free_q <= ~commit_used;
      tail_q <= head_q;
      cnt_q  <= '0;
    end else begin
      if (alloc) begin
        free_q[pick]       <= 1'b0;
        front_map[ren_dst] <= pick;
      end
      if (fire) tail_q <= tail_q + 1'b1;
      if (retire) begin
        head_q <= head_q + 1'b1;
        if (ret_dst) begin
          free_q[commit_map[ret_arch]] <= 1'b1;
          commit_map[ret_arch]         <= ret_tag;
        end
      end
      cnt_q <= cnt_q + CW'(fire) - CW'(retire);
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      ent_dst[tail_q]  <= ren_has_dst;
      ent_arch[tail_q] <= ren_dst;
      ent_tag[tail_q]  <= pick;
    end
  end

  assert_rob_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(ROB_DEPTH));
  assert_full_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !ren_ready);
  assert_alloc_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !flush) |=> !free_q[$past(ren_tag_dst)]);
  assert_nodst_keeps_pool_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ren_has_dst && !retire) |=> $stable(free_q));
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && tail_q == head_q));
  assert_empty_retire_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !flush) |=> $stable(head_q));
endmodule

// File: tb/rename_map_unit_bench.sv
`timescale 1ns/1ps
module rename_map_unit_bench;
  localparam int NA = 8, NP = 128, ND = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ren_valid = 0, ren_has_dst = 0, ret_valid = 0, flush = 0;
  logic [2:0] ren_src_a = 0, ren_src_b = 0, ren_dst = 0;
  logic ren_ready;
  logic [6:0] ren_tag_a, ren_tag_b, ren_tag_dst, ren_rob_idx;

  rename_map_unit u_rename_map_unit (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src_a(ren_src_a),
    .ren_src_b(ren_src_b), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b),
    .ren_tag_dst(ren_tag_dst), .ren_rob_idx(ren_rob_idx),
    .ret_valid(ret_valid), .flush(flush));

  int checks = 0, fails = 0;

  typedef struct packed {
    logic rdy; logic chkd; logic [6:0] ta, tb, td, rob;
  } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  int m_front[NA], m_commit[NA];
  bit m_free[NP];
  int m_head, m_tail, m_cnt;
  bit r_dst[ND];
  int r_arch[ND], r_tag[ND];

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input bit rv, input int sa, input int sb, input bit hd, input int d,
                      input bit rt, input bit fl, input string tag);
    bit rdy, fire, ret_ok;
    int p;
    exp_t e;
    @(posedge clk); #1;
    ren_valid = rv; ren_src_a = 3'(sa); ren_src_b = 3'(sb);
    ren_has_dst = hd; ren_dst = 3'(d); ret_valid = rt; flush = fl;
    p = lowest_free();
    rdy = !fl && (m_cnt < ND) && (!hd || p >= 0);
    if (rv) begin
      e.rdy = rdy; e.chkd = hd && rdy;
      e.ta = 7'(m_front[sa]); e.tb = 7'(m_front[sb]);
      e.td = 7'(p < 0 ? 0 : p); e.rob = 7'(m_tail);
      exp_q.push_back(e); tag_q.push_back(tag);
    end
    fire = rv && rdy;
    ret_ok = rt && !fl && m_cnt > 0;
    if (fl) begin
      for (int a = 0; a < NA; a++) m_front[a] = m_commit[a];
      for (int i = 0; i < NP; i++) m_free[i] = 1;
      for (int a = 0; a < NA; a++) m_free[m_commit[a]] = 0;
      m_tail = m_head; m_cnt = 0;
    end else begin
      if (fire) begin
        r_dst[m_tail] = hd; r_arch[m_tail] = d; r_tag[m_tail] = p;
        if (hd) begin m_free[p] = 0; m_front[d] = p; end
        m_tail = (m_tail + 1) % ND; m_cnt++;
      end
      if (ret_ok) begin
        if (r_dst[m_head]) begin
          m_free[m_commit[r_arch[m_head]]] = 1;
          m_commit[r_arch[m_head]] = r_tag[m_head];
        end
        m_head = (m_head + 1) % ND; m_cnt--;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ren_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "scoreboard underflow", 0, 1);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(ren_ready == e.rdy, {t, " ready"}, ren_ready, e.rdy);
        if (e.rdy) begin
          check(ren_tag_a == e.ta, {t, " src_a tag"}, ren_tag_a, e.ta);
          check(ren_tag_b == e.tb, {t, " src_b tag"}, ren_tag_b, e.tb);
          check(ren_rob_idx == e.rob, {t, " rob slot R4"}, ren_rob_idx, e.rob);
          if (e.chkd) check(ren_tag_dst == e.td, {t, " dst tag"}, ren_tag_dst, e.td);
        end
      end
    end
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < NA; a++) begin m_front[a] = a; m_commit[a] = a; end
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
    m_head = 0; m_tail = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(ren_ready == 1'b1, "R1 ready after reset", ren_ready, 1);
    check(ren_rob_idx == 0, "R1 slot after reset", ren_rob_idx, 0);
    for (int a = 0; a < 4; a++) step(1, 2 * a, 2 * a + 1, 0, 0, 0, 0, "R1");
    step(1, 3, 3, 1, 3, 0, 0, "R3");
    step(1, 3, 0, 1, 3, 0, 0, "R2");
    step(1, 3, 5, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 3, 3, 1, 1, 0, 0, "R7 freed reuse");
    step(1, 3, 1, 0, 0, 1, 1, "R8 flush stall");
    step(0, 0, 0, 0, 0, 1, 0, "R7 empty retire");
    step(1, 1, 3, 0, 0, 0, 0, "R8 recovered map");
    step(1, 2, 4, 1, 2, 0, 1, "R8");
    for (int i = 0; i < 130; i++) step(1, i % 8, (i + 3) % 8, 1, i % 8, 0, 0, "R6 drain");
    step(1, 0, 1, 0, 0, 0, 0, "R6 no-dst proceeds");
    for (int i = 0; i < 10; i++) step(1, i % 8, 7, 0, 0, 0, 0, "R5 fill");
    for (int i = 0; i < 200; i++)
      step(1, i % 8, (i + 5) % 8, (i % 3) != 0, (i + 1) % 8, 1, 0, "R4 wrap");
    step(0, 0, 0, 0, 0, 0, 1, "R8");
    for (int a = 0; a < 8; a++) step(1, a, 7 - a, 1, a, 0, 0, "R8 after flush");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule